// File: doc/BRIEF.md
# 16-bit Capture/Reload Timer with Serial Clock Output

This block is a 16-bit up-counter with an 8-bit control register. It counts either internal ticks from a prescaler (one tick every 12 clocks, or every 6 when the fast-mode input is high) or falling edges on an external count pin. Three behaviours are built around the counter:

- **Auto-reload:** on overflow, the counter restarts from a 16-bit reload register.
- **Capture:** a falling edge on a trigger pin copies the counter into a capture register.
- **Serial clock generation:** the counter always reloads on overflow, and its overflow pulses clock a serial port's receive side, transmit side, or both.

Software reaches the control register, the counter, the reload register and the capture register through a simple byte-wide register bus. The control register can also be changed one bit at a time through a separate bit-write port. Two sticky flags record events, and an interrupt line combines them: one flag records counter overflow, the other records a trigger-pin event. The block carries no data stream, so it has no valid/ready handshake: the bus and the pins are plain level signals, and the bus never applies back-pressure.

Both pins idle high. Each pin passes through a two-flop synchronizer and an edge register before it is used.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00, and `irq`, `ovf_pulse`, `rx_clk_pulse` and `tx_clk_pulse` are low.
- R2: The bus address map is 0 = control, 1/2 = counter low/high, 3/4 = reload low/high, 5/6 = capture low/high. A read returns the stored byte in the same cycle. The control bits, from bit 7 down to bit 0, are: overflow flag, trigger flag, receive-clock select, transmit-clock select, trigger enable, run, count-pin select, capture select. A bit write sets bit `bit_sel` to `bit_val`.
- R3: With run=1 and count-pin select=0, the counter increments once every 12 clocks, or every 6 when `fast_mode`=1. The first increment lands 12 (or 6) clocks after the write that sets run.
- R4: With run=1 and count-pin select=1, each falling edge of `count_pin` increments the counter once. The new value is visible 3 clocks after the pin falls.
- R5: With run=0, the counter neither increments nor overflows, in either count source.
- R6: With capture select=0 and both clock selects 0, an overflow loads the reload value and sets the overflow flag. It also gives a one-clock `ovf_pulse` in the cycle after the overflowing edge.
- R7: With capture select=1 and trigger enable=1, a trigger-pin falling edge copies the counter into the capture register and sets the trigger flag. The counter is not changed. In this mode an overflow wraps the counter to 0x0000 and sets the overflow flag.
- R8: With capture select=0 and trigger enable=1, a trigger-pin falling edge loads the reload value into the counter and sets the trigger flag.
- R9: With trigger enable=0, a trigger-pin edge changes neither the counter, the capture register nor the trigger flag.
- R10: While either clock select is 1:
  - an overflow always reloads, whatever the capture select;
  - the overflow flag is not set;
  - trigger-pin edges are ignored even with trigger enable=1;
  - `rx_clk_pulse` and `tx_clk_pulse` copy `ovf_pulse` only when their own select bit is 1.
- R11: Both flags stay set until software writes them to 0. If a flag-setting event and a software clear fall in the same cycle, the flag ends set.
- R12: `irq` is high when the overflow flag is set, or when the trigger flag is set and `updown_en` is 0.
- R13: A bus write to a counter byte takes priority over an increment or reload in the same cycle. The other byte keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| bit_wr | input | 1 | Single-bit write strobe for the control register |
| bit_sel | input | 3 | Control bit index for a bit write |
| bit_val | input | 1 | Value for a bit write |
| count_pin | input | 1 | External event input; falling edges are counted |
| trig_pin | input | 1 | External trigger; a falling edge causes a capture or a reload |
| fast_mode | input | 1 | Prescaler divides by 6 instead of 12 |
| updown_en | input | 1 | Up/down counting option active; masks the trigger flag from `irq` |
| irq | output | 1 | Interrupt request |
| ovf_pulse | output | 1 | One-clock pulse per overflow |
| rx_clk_pulse | output | 1 | Overflow pulse gated by the receive-clock select |
| tx_clk_pulse | output | 1 | Overflow pulse gated by the transmit-clock select |

## Verification
Register effects of a bus write are due in the cycle after the write edge, and reads are compared in the same cycle that the address is driven. A pin falling edge changes the counter, the capture register or a flag 3 clocks later. The matching `ovf_pulse` and its gated copies are high in exactly that third cycle and low in the cycles on either side. A timer-mode increment lands exactly 12 (or 6) clocks after the run edge. Every expected value is queued with the cycle number in which it is due. The monitor compares it at the falling clock edge of that cycle, and it reports any item whose cycle has passed without a comparison.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CNT_W  = 16;
  localparam int NB     = CNT_W / 8;
  localparam int ADDR_W = 3;

  // register map
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam int A_CNT = 1;
  localparam int A_RLD = A_CNT + NB;
  localparam int A_CAP = A_RLD + NB;

  // control bit positions
  localparam int B_OVF  = 7;
  localparam int B_EXT  = 6;
  localparam int B_RXS  = 5;
  localparam int B_TXS  = 4;
  localparam int B_EXEN = 3;
  localparam int B_RUN  = 2;
  localparam int B_CNTM = 1;
  localparam int B_CAPM = 0;
endpackage

// File: rtl/ct_edge_sync.sv
module ct_edge_sync #(
  parameter int STAGES = 2,
  parameter bit IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  // sh[STAGES-1] is the synchronized sample, sh[STAGES] the previous one
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= {(STAGES+1){IDLE}};
    else     sh <= {sh[STAGES-1:0], pin};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
  parameter int DIV_STD  = 12,
  parameter int DIV_FAST = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fast,
  output logic tick
);
  localparam int PW = $clog2(DIV_STD + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] limit;

  assign limit = fast ? PW'(DIV_FAST - 1) : PW'(DIV_STD - 1);
  assign tick  = run && (pre_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run || tick) pre_q <= '0;
    else                     pre_q <= pre_q + PW'(1);
  end
endmodule

// File: rtl/ct_count_core.sv
module ct_count_core
  import ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              trig,
  input  logic              baud,
  input  logic              capm,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  rld_q,
  output logic [CNT_W-1:0]  cap_q,
  output logic              ovf
);
  logic [NB-1:0]    cnt_lane, rld_lane, cap_lane;
  logic [CNT_W-1:0] cnt_nxt, rld_nxt, cap_nxt;
  logic             reload_now, capture_now;

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign cnt_lane[b] = bus_wr && (bus_addr == ADDR_W'(A_CNT + b));
    assign rld_lane[b] = bus_wr && (bus_addr == ADDR_W'(A_RLD + b));
    assign cap_lane[b] = bus_wr && (bus_addr == ADDR_W'(A_CAP + b));
  end

  assign ovf         = inc && (&cnt_q);
  // serial-clock mode forces reload; trig arrives already qualified
  assign reload_now  = (ovf && (baud || !capm)) || (trig && !capm);
  assign capture_now = trig && capm;

  always_comb begin
    cnt_nxt = cnt_q;
    if (reload_now)  cnt_nxt = rld_q;
    else if (inc)    cnt_nxt = cnt_q + CNT_W'(1);
    if (|cnt_lane) begin
      cnt_nxt = cnt_q;
      for (int b = 0; b < NB; b++)
        if (cnt_lane[b]) cnt_nxt[8*b +: 8] = bus_wdata;
    end
  end

  always_comb begin
    rld_nxt = rld_q;
    for (int b = 0; b < NB; b++)
      if (rld_lane[b]) rld_nxt[8*b +: 8] = bus_wdata;
  end

  always_comb begin
    cap_nxt = cap_q;
    if (capture_now) cap_nxt = cnt_q;
    if (|cap_lane) begin
      cap_nxt = cap_q;
      for (int b = 0; b < NB; b++)
        if (cap_lane[b]) cap_nxt[8*b +: 8] = bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      rld_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      rld_q <= rld_nxt;
      cap_q <= cap_nxt;
    end
  end
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
  import ct_pkg::*;
#(
  parameter int DIV_STD     = 12,
  parameter int DIV_FAST    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              bit_wr,
  input  logic [2:0]        bit_sel,
  input  logic              bit_val,
  input  logic              count_pin,
  input  logic              trig_pin,
  input  logic              fast_mode,
  input  logic              updown_en,
  output logic              irq,
  output logic              ovf_pulse,
  output logic              rx_clk_pulse,
  output logic              tx_clk_pulse
);
  localparam int NPIN = 2;

  logic [7:0]       ctl_q, ctl_nxt;
  logic [NPIN-1:0]  pin_in, pin_fall;
  logic             tick, inc, ovf, baud, trig_q;
  logic [CNT_W-1:0] cnt_q, rld_q, cap_q;

  // index 0: count pin, index 1: trigger pin
  assign pin_in = {trig_pin, count_pin};

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    ct_edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_sync (
      .clk (clk),
      .rst (rst),
      .pin (pin_in[g]),
      .fall(pin_fall[g])
    );
  end

  ct_prescaler #(.DIV_STD(DIV_STD), .DIV_FAST(DIV_FAST)) u_pre (
    .clk (clk),
    .rst (rst),
    .run (ctl_q[B_RUN]),
    .fast(fast_mode),
    .tick(tick)
  );

  assign baud   = ctl_q[B_RXS] | ctl_q[B_TXS];
  assign inc    = ctl_q[B_RUN] && (ctl_q[B_CNTM] ? pin_fall[0] : tick);
  assign trig_q = pin_fall[1] && ctl_q[B_EXEN] && !baud;

  ct_count_core u_core (
    .clk      (clk),
    .rst      (rst),
    .inc      (inc),
    .trig     (trig_q),
    .baud     (baud),
    .capm     (ctl_q[B_CAPM]),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .cnt_q    (cnt_q),
    .rld_q    (rld_q),
    .cap_q    (cap_q),
    .ovf      (ovf)
  );

  // software writes first, hardware flag setting last so it wins
  always_comb begin
    ctl_nxt = ctl_q;
    if (bus_wr && bus_addr == A_CTRL) ctl_nxt = bus_wdata;
    if (bit_wr) ctl_nxt[bit_sel] = bit_val;
    if (ovf && !baud) ctl_nxt[B_OVF] = 1'b1;
    if (trig_q)       ctl_nxt[B_EXT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q        <= '0;
      ovf_pulse    <= 1'b0;
      rx_clk_pulse <= 1'b0;
      tx_clk_pulse <= 1'b0;
    end else begin
      ctl_q        <= ctl_nxt;
      ovf_pulse    <= ovf;
      rx_clk_pulse <= ovf && ctl_q[B_RXS];
      tx_clk_pulse <= ovf && ctl_q[B_TXS];
    end
  end

  assign irq = ctl_q[B_OVF] | (ctl_q[B_EXT] & ~updown_en);

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_CTRL) bus_rdata = ctl_q;
    for (int b = 0; b < NB; b++) begin
      if (bus_addr == ADDR_W'(A_CNT + b)) bus_rdata = cnt_q[8*b +: 8];
      if (bus_addr == ADDR_W'(A_RLD + b)) bus_rdata = rld_q[8*b +: 8];
      if (bus_addr == ADDR_W'(A_CAP + b)) bus_rdata = cap_q[8*b +: 8];
    end
  end
endmodule

// File: rtl/ct_checker.sv
module ct_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic [2:0] bus_addr,
  input logic       bit_wr,
  input logic       ovf_flag,
  input logic       ext_flag,
  input logic       rx_sel,
  input logic       tx_sel,
  input logic       run_bit,
  input logic       updown_en,
  input logic       irq,
  input logic       ovf_pulse,
  input logic       rx_clk_pulse,
  input logic       tx_clk_pulse
);
  logic sw_ctl;
  assign sw_ctl = (bus_wr && bus_addr == 3'd0) || bit_wr;

  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse |=> !ovf_pulse);

  assert_run_off_R5: assert property (@(posedge clk) disable iff (rst)
    !run_bit |=> !ovf_pulse);

  assert_rx_gated_R10: assert property (@(posedge clk) disable iff (rst)
    rx_clk_pulse |-> ovf_pulse);

  assert_tx_gated_R10: assert property (@(posedge clk) disable iff (rst)
    tx_clk_pulse |-> ovf_pulse);

  assert_no_flag_baud_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_sel || tx_sel) && !ovf_flag && !sw_ctl |=> !ovf_flag);

  assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !sw_ctl |=> ovf_flag);

  assert_ext_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    ext_flag && !sw_ctl |=> ext_flag);

  assert_irq_ovf_R12: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> irq);

  assert_irq_mask_R12: assert property (@(posedge clk) disable iff (rst)
    updown_en && !ovf_flag |-> !irq);
endmodule

bind cap_reload_timer ct_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bit_wr      (bit_wr),
  .ovf_flag    (ctl_q[7]),
  .ext_flag    (ctl_q[6]),
  .rx_sel      (ctl_q[5]),
  .tx_sel      (ctl_q[4]),
  .run_bit     (ctl_q[2]),
  .updown_en   (updown_en),
  .irq         (irq),
  .ovf_pulse   (ovf_pulse),
  .rx_clk_pulse(rx_clk_pulse),
  .tx_clk_pulse(tx_clk_pulse)
);

// File: tb/cap_reload_timer_test.sv
module cap_reload_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bit_wr = 1'b0, bit_val = 1'b0;
  logic [2:0] bus_addr = '0, bit_sel = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       count_pin = 1'b1, trig_pin = 1'b1, fast_mode = 1'b0, updown_en = 1'b0;
  logic       irq, ovf_pulse, rx_clk_pulse, tx_clk_pulse;

  always #5 clk = ~clk;

  cap_reload_timer uut (.*);

  localparam int P_RD = 0, P_OVF = 1, P_RX = 2, P_TX = 3, P_IRQ = 4;

  typedef struct {
    int         due;
    int         probe;
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    n_chk = 0, n_fail = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] probe_val(int p);
    case (p)
      P_RD:    return bus_rdata;
      P_OVF:   return {7'd0, ovf_pulse};
      P_RX:    return {7'd0, rx_clk_pulse};
      P_TX:    return {7'd0, tx_clk_pulse};
      default: return {7'd0, irq};
    endcase
  endfunction

  // monitor: compares every queued item in its due cycle
  always @(negedge clk) begin
    for (int i = sbq.size() - 1; i >= 0; i--) begin
      if (sbq[i].due == cyc) begin
        logic [7:0] act;
        act = probe_val(sbq[i].probe);
        n_chk++;
        if (act !== sbq[i].exp) begin
          n_fail++;
          $display("FAIL %s probe %0d cycle %0d: actual %h expected %h",
                   sbq[i].req, sbq[i].probe, cyc, act, sbq[i].exp);
        end
        sbq.delete(i);
      end else if (sbq[i].due < cyc) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s probe %0d missed: actual none expected %h",
                 sbq[i].req, sbq[i].probe, sbq[i].exp);
        sbq.delete(i);
      end
    end
  end

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic push(int p, logic [7:0] e, int due, string r);
    item_t it;
    it.due = due; it.probe = p; it.exp = e; it.req = r;
    sbq.push_back(it);
  endtask

  task automatic wr(int a, logic [7:0] d);
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic bitw(int i, logic v);
    bit_wr = 1'b1; bit_sel = 3'(i); bit_val = v;
    step();
    bit_wr = 1'b0;
  endtask

  task automatic rd(int a, logic [7:0] e, string r);
    bus_addr = 3'(a);
    push(P_RD, e, cyc, r);
    step();
  endtask

  task automatic chk(int p, logic [7:0] e, string r);
    push(p, e, cyc, r);
    step();
  endtask

  task automatic set16(int base, logic [15:0] v);
    wr(base, v[7:0]);
    wr(base + 1, v[15:8]);
  endtask

  task automatic rd16(int base, logic [15:0] v, string r);
    rd(base, v[7:0], r);
    rd(base + 1, v[15:8], r);
  endtask

  task automatic expect_pulse(int p, logic v, string r);
    push(p, 8'd0, cyc + 2, r);
    push(p, {7'd0, v}, cyc + 3, r);
    push(p, 8'd0, cyc + 4, r);
  endtask

  task automatic cnt_edge();
    count_pin = 1'b0; step(4);
    count_pin = 1'b1; step(4);
  endtask

  task automatic trig_edge();
    trig_pin = 1'b0; step(4);
    trig_pin = 1'b1; step(4);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    step(3);
    rst = 1'b0;

    // R1 reset state
    rd(0, 8'h00, "R1");
    rd16(1, 16'h0000, "R1");
    rd16(3, 16'h0000, "R1");
    rd16(5, 16'h0000, "R1");
    chk(P_IRQ, 8'd0, "R1");
    chk(P_OVF, 8'd0, "R1");
    chk(P_RX, 8'd0, "R1");

    // R2 register map and bit writes
    set16(1, 16'h1234); rd16(1, 16'h1234, "R2");
    set16(3, 16'hCDAB); rd16(3, 16'hCDAB, "R2");
    set16(5, 16'h5566); rd16(5, 16'h5566, "R2");
    bitw(3, 1'b1); rd(0, 8'h08, "R2");
    bitw(3, 1'b0); rd(0, 8'h00, "R2");

    // R4 counting pin edges, 3-clock latency
    wr(0, 8'h06);
    count_pin = 1'b0; step(2);
    rd(1, 8'h34, "R4");
    rd(1, 8'h35, "R4");
    step(2); count_pin = 1'b1; step(4);
    cnt_edge(); cnt_edge();
    rd16(1, 16'h1237, "R4");

    // R5 run off
    wr(0, 8'h02);
    cnt_edge(); cnt_edge();
    rd16(1, 16'h1237, "R5");
    wr(0, 8'h00); step(30);
    rd16(1, 16'h1237, "R5");

    // R3 prescaled timer, divide by 12
    set16(1, 16'h0000);
    wr(0, 8'h04);
    step(11);
    rd(1, 8'h00, "R3");
    rd(1, 8'h01, "R3");
    step(10);
    rd(1, 8'h01, "R3");
    rd(1, 8'h02, "R3");
    // R3 divide by 6
    wr(0, 8'h00); fast_mode = 1'b1;
    set16(1, 16'h0000);
    wr(0, 8'h04);
    step(5);
    rd(1, 8'h00, "R3");
    rd(1, 8'h01, "R3");
    wr(0, 8'h00); fast_mode = 1'b0;

    // R6 auto-reload on overflow
    set16(1, 16'hFFFF);
    wr(0, 8'h06);
    expect_pulse(P_OVF, 1'b1, "R6");
    expect_pulse(P_RX, 1'b0, "R10");
    expect_pulse(P_TX, 1'b0, "R10");
    cnt_edge();
    rd16(1, 16'hCDAB, "R6");
    rd(0, 8'h86, "R6");
    chk(P_IRQ, 8'd1, "R12");
    wr(0, 8'h06);
    rd(0, 8'h06, "R11");
    chk(P_IRQ, 8'd0, "R12");

    // R7 capture on trigger
    set16(1, 16'h0042);
    wr(0, 8'h0F);
    trig_edge();
    rd16(5, 16'h0042, "R7");
    rd16(1, 16'h0042, "R7");
    rd(0, 8'h4F, "R7");
    chk(P_IRQ, 8'd1, "R12");
    updown_en = 1'b1;
    chk(P_IRQ, 8'd0, "R12");
    updown_en = 1'b0;
    // R7 overflow in capture mode wraps
    set16(1, 16'hFFFF);
    expect_pulse(P_OVF, 1'b1, "R7");
    cnt_edge();
    rd16(1, 16'h0000, "R7");
    rd(0, 8'hCF, "R7");

    // R8 trigger reload
    wr(0, 8'h0E);
    set16(1, 16'h0077);
    trig_edge();
    rd16(1, 16'hCDAB, "R8");
    rd(0, 8'h4E, "R8");
    rd16(5, 16'h0042, "R8");

    // R9 trigger ignored with enable off
    wr(0, 8'h06);
    set16(1, 16'h0077);
    trig_edge();
    rd16(1, 16'h0077, "R9");
    rd(0, 8'h06, "R9");
    wr(0, 8'h07);
    trig_edge();
    rd16(5, 16'h0042, "R9");
    rd(0, 8'h07, "R9");

    // R10 serial clock mode, receive select
    wr(0, 8'h2F);
    set16(1, 16'hFFFF);
    expect_pulse(P_OVF, 1'b1, "R10");
    expect_pulse(P_RX, 1'b1, "R10");
    expect_pulse(P_TX, 1'b0, "R10");
    cnt_edge();
    rd16(1, 16'hCDAB, "R10");
    rd(0, 8'h2F, "R10");
    trig_edge();
    rd16(5, 16'h0042, "R10");
    rd16(1, 16'hCDAB, "R10");
    rd(0, 8'h2F, "R10");
    // R10 transmit select
    wr(0, 8'h16);
    set16(1, 16'hFFFF);
    expect_pulse(P_RX, 1'b0, "R10");
    expect_pulse(P_TX, 1'b1, "R10");
    cnt_edge();
    rd(0, 8'h16, "R10");

    // R11 set wins over same-cycle clear, then sticky
    wr(0, 8'h06);
    set16(1, 16'hFFFF);
    count_pin = 1'b0; step(2);
    wr(0, 8'h06);
    rd(0, 8'h86, "R11");
    step(2); count_pin = 1'b1; step(4);
    rd(0, 8'h86, "R11");
    bitw(7, 1'b0);
    rd(0, 8'h06, "R11");

    // R13 bus write beats increment
    set16(1, 16'h0010);
    count_pin = 1'b0; step(2);
    wr(1, 8'h50);
    rd16(1, 16'h0050, "R13");
    step(2); count_pin = 1'b1; step(4);
    rd16(1, 16'h0050, "R13");

    step(6);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule